// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between the memory stage of a pipeline and a 32-bit data memory that is addressed by word. It adds the base register value to the sign-extended 12-bit offset to form the effective address. It then decodes the access size and signedness from the 3-bit funct3 field. From these it produces the word address, the four byte strobes, the store data placed on the byte lanes, and the load result taken from the returned word and extended to 32 bits.

The block is purely combinational. The memory stage drives the operands and funct3, and the memory consumes `memAddr`, `byteEn` and `storeLanes`. On a load, the word the memory returns comes back in on `readWord` and leaves as `loadResult`. Halfword or word accesses that do not sit on their natural boundary raise `misaligned`. Unknown size codes raise `illegalSize`. In both cases no strobe fires.

Top module: `lsu_lane_align`

## Requirements
- R1: `memAddr` equals `baseAddr` plus `immOffset` sign-extended from bit 11, with bits [1:0] forced to zero.
- R2: funct3 value 000 is a signed byte, 001 a signed halfword, 010 a word, 100 an unsigned byte and 101 an unsigned halfword. Any other value raises `illegalSize`, drives `byteEn` to 0000 and `loadResult` to zero, and leaves `misaligned` low.
- R3: For a legal aligned access, with offset o = effective address [1:0], `byteEn` bit i maps to data bits [8i+7:8i]. A byte access sets only bit o. A halfword access sets 0011 shifted left by o. A word access sets 1111.
- R4: A halfword access with an odd offset, or a word access with a nonzero offset, raises `misaligned` and drives `byteEn` to 0000.
- R5: On `storeLanes`, a byte access repeats `storeData[7:0]` in all four lanes. A halfword access repeats `storeData[15:0]` in both halves. A word access or an illegal code passes `storeData` unchanged.
- R6: A signed byte load returns the byte in lane o, and a signed halfword load returns lanes o and o+1. Each is sign-extended to 32 bits from its top bit.
- R7: An unsigned byte or halfword load returns the same selected bytes, zero-extended to 32 bits.
- R8: An aligned word load returns `readWord` unchanged.
- R9: A misaligned access drives `loadResult` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| baseAddr | input | 32 | Base register value |
| immOffset | input | 12 | Signed address offset |
| funct3 | input | 3 | Access size and signedness code |
| storeData | input | 32 | Source register value for stores |
| readWord | input | 32 | Word returned by the data memory |
| memAddr | output | 32 | Word-aligned memory address |
| byteEn | output | 4 | Byte-lane write strobes |
| storeLanes | output | 32 | Store data placed on the byte lanes |
| loadResult | output | 32 | Extracted and extended load value |
| misaligned | output | 1 | Access crosses its natural boundary |
| illegalSize | output | 1 | funct3 is not a defined size code |

## Verification
Byte accesses are tried at every offset with a returned word whose four lanes hold different values, each with its top bit set or clear. This tells a wrong lane choice apart from a wrong extension. Halfword accesses at offsets 0 and 2 tell upper-half from lower-half selection. Offsets 1 and 3 show the misaligned path and its zeroed strobes. Negative and positive offsets that carry across the low address bits show whether the offset is taken from the sum rather than from the base alone. Every undefined funct3 code is driven to show that it stays quiet.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  // funct3 size codes
  localparam logic [2:0] F3_BYTE_S = 3'b000;
  localparam logic [2:0] F3_HALF_S = 3'b001;
  localparam logic [2:0] F3_WORD   = 3'b010;
  localparam logic [2:0] F3_BYTE_U = 3'b100;
  localparam logic [2:0] F3_HALF_U = 3'b101;

  // strobes from control to datapath
  typedef struct packed {
    logic isByte;
    logic isHalf;
    logic isWord;
    logic signExt;
    logic blocked;   // illegal or misaligned: suppress load result
  } laneCtrl_t;

endpackage

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_lane_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [2:0]       funct3,
  input  logic [OFS_W-1:0] laneOfs,
  output laneCtrl_t        ctl,
  output logic [LANES-1:0] byteEn,
  output logic             misaligned,
  output logic             illegalSize
);

  logic isByte, isHalf, isWord;

  always_comb begin
    isByte = 1'b0;
    isHalf = 1'b0;
    isWord = 1'b0;
    unique case (funct3)
      F3_BYTE_S, F3_BYTE_U: isByte = 1'b1;
      F3_HALF_S, F3_HALF_U: isHalf = 1'b1;
      F3_WORD:              isWord = 1'b1;
      default: ;
    endcase
  end

  assign illegalSize = ~(isByte | isHalf | isWord);
  assign misaligned  = (isHalf & laneOfs[0]) | (isWord & (laneOfs != '0));

  logic [LANES-1:0] rawEn;
  for (genvar i = 0; i < LANES; i++) begin : g_lane_en
    assign rawEn[i] = (isByte & (laneOfs == OFS_W'(i)))
                    | (isHalf & (laneOfs[OFS_W-1:1] == (OFS_W-1)'(i / 2)))
                    | isWord;
  end

  assign byteEn = (misaligned | illegalSize) ? '0 : rawEn;

  assign ctl.isByte  = isByte;
  assign ctl.isHalf  = isHalf;
  assign ctl.isWord  = isWord;
  assign ctl.signExt = ~funct3[2];
  assign ctl.blocked = misaligned | illegalSize;

  always_comb begin
    if (isByte) begin
      a_r3_byte_one_strobe: assert ($countones(byteEn) == 1);
    end
    if (misaligned) begin
      a_r4_misaligned_no_strobe: assert (byteEn == '0);
    end
    if (illegalSize) begin
      a_r2_illegal_quiet: assert (!misaligned && byteEn == '0);
    end
  end

endmodule

// File: rtl/lsu_lane_data.sv
module lsu_lane_data
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IMM_W-1:0]  immOffset,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] readWord,
  input  laneCtrl_t         ctl,
  output logic [OFS_W-1:0]  laneOfs,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] storeLanes,
  output logic [DATA_W-1:0] loadResult
);

  logic [ADDR_W-1:0] effAddr;
  assign effAddr = baseAddr + {{(ADDR_W-IMM_W){immOffset[IMM_W-1]}}, immOffset};
  assign laneOfs = effAddr[OFS_W-1:0];
  assign memAddr = {effAddr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  for (genvar i = 0; i < LANES; i++) begin : g_st_lane
    always_comb begin
      if (ctl.isByte)      storeLanes[i*8 +: 8] = storeData[7:0];
      else if (ctl.isHalf) storeLanes[i*8 +: 8] = storeData[(i % 2)*8 +: 8];
      else                 storeLanes[i*8 +: 8] = storeData[i*8 +: 8];
    end
  end

  logic [DATA_W-1:0] shifted, byteVal, halfVal;
  assign shifted = readWord >> {laneOfs, 3'b000};
  assign byteVal = {{(DATA_W-8){ctl.signExt & shifted[7]}}, shifted[7:0]};
  assign halfVal = {{(DATA_W-16){ctl.signExt & shifted[15]}}, shifted[15:0]};

  always_comb begin
    if (ctl.blocked)     loadResult = '0;
    else if (ctl.isByte) loadResult = byteVal;
    else if (ctl.isHalf) loadResult = halfVal;
    else                 loadResult = shifted;
  end

  always_comb begin
    if (ctl.isByte) begin
      a_r5_byte_replicated: assert (storeLanes[15:8] == storeLanes[7:0]);
    end
    if (ctl.isHalf && !ctl.signExt && !ctl.blocked) begin
      a_r7_half_zero_upper: assert (loadResult[DATA_W-1:16] == '0);
    end
    if (ctl.isWord && !ctl.blocked) begin
      a_r8_word_passthrough: assert (loadResult == readWord);
    end
  end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IMM_W-1:0]  immOffset,
  input  logic [2:0]        funct3,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] readWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] storeLanes,
  output logic [DATA_W-1:0] loadResult,
  output logic              misaligned,
  output logic              illegalSize
);

  laneCtrl_t        ctl;
  logic [OFS_W-1:0] laneOfs;

  lsu_lane_ctrl #(.LANES(LANES)) i_ctrl (
    .funct3      (funct3),
    .laneOfs     (laneOfs),
    .ctl         (ctl),
    .byteEn      (byteEn),
    .misaligned  (misaligned),
    .illegalSize (illegalSize)
  );

  lsu_lane_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) i_data (
    .baseAddr   (baseAddr),
    .immOffset  (immOffset),
    .storeData  (storeData),
    .readWord   (readWord),
    .ctl        (ctl),
    .laneOfs    (laneOfs),
    .memAddr    (memAddr),
    .storeLanes (storeLanes),
    .loadResult (loadResult)
  );

endmodule

// File: tb/test_lsu_lane_align.sv
module test_lsu_lane_align;

  logic        clk = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [11:0] immOffset = '0;
  logic [2:0]  funct3 = '0;
  logic [31:0] storeData = '0;
  logic [31:0] readWord = '0;
  logic [31:0] memAddr, storeLanes, loadResult;
  logic [3:0]  byteEn;
  logic        misaligned, illegalSize;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lsu_lane_align i_lsu_lane_align (
    .baseAddr(baseAddr), .immOffset(immOffset), .funct3(funct3),
    .storeData(storeData), .readWord(readWord), .memAddr(memAddr),
    .byteEn(byteEn), .storeLanes(storeLanes), .loadResult(loadResult),
    .misaligned(misaligned), .illegalSize(illegalSize)
  );

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one access and compare every output with values derived from the requirements
  task automatic access(string req, logic [31:0] b, logic [11:0] im, logic [2:0] f3,
                        logic [31:0] sd, logic [31:0] rw);
    logic [31:0] eff, expSt, expLd, sh;
    logic [1:0]  o;
    logic [3:0]  expBe;
    logic        ill, mis;
    int          sz;
    @(posedge clk);
    baseAddr = b; immOffset = im; funct3 = f3; storeData = sd; readWord = rw;
    eff = b + {{20{im[11]}}, im};
    o   = eff[1:0];
    case (f3)
      3'b000, 3'b100: sz = 1;
      3'b001, 3'b101: sz = 2;
      3'b010:         sz = 4;
      default:        sz = 0;
    endcase
    ill   = (sz == 0);
    mis   = (sz == 2 && o[0]) || (sz == 4 && o != 2'd0);
    expBe = (ill || mis) ? 4'h0 : (sz == 1) ? (4'h1 << o) : (sz == 2) ? (4'h3 << o) : 4'hF;
    expSt = (sz == 1) ? {4{sd[7:0]}} : (sz == 2) ? {2{sd[15:0]}} : sd;
    sh    = rw >> (8 * o);
    if (ill || mis) expLd = '0;
    else if (sz == 1) expLd = f3[2] ? {24'h0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
    else if (sz == 2) expLd = f3[2] ? {16'h0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
    else expLd = rw;
    @(negedge clk);
    cmp(req, "memAddr", memAddr, {eff[31:2], 2'b00});
    cmp(req, "byteEn", {28'h0, byteEn}, {28'h0, expBe});
    cmp(req, "storeLanes", storeLanes, expSt);
    cmp(req, "loadResult", loadResult, expLd);
    cmp(req, "misaligned", {31'h0, misaligned}, {31'h0, mis});
    cmp(req, "illegalSize", {31'h0, illegalSize}, {31'h0, ill});
  endtask

  task automatic testIdle;  // all-zero inputs: signed byte at address 0
    access("R1", 32'h0, 12'h0, 3'b000, 32'h0, 32'h0);
    cmp("R3", "idle byteEn", {28'h0, byteEn}, 32'h1);
  endtask

  task automatic testAddress;
    access("R1", 32'h0000_1003, 12'hFFD, 3'b010, 32'h1, 32'h2);  // -3 -> 0x1000
    access("R1", 32'h0000_0FFE, 12'h006, 3'b010, 32'h1, 32'h2);  // carry into bit 12
    access("R1", 32'h8000_0000, 12'h800, 3'b000, 32'h1, 32'h2);  // -2048 wraps
    cmp("R1", "wrapped memAddr", memAddr, 32'h7FFF_F800);
  endtask

  task automatic testBytes;
    for (int o = 0; o < 4; o++) begin
      access("R6", 32'h200 + o, 12'h0, 3'b000, 32'hA5A5_A55A, 32'h80_7F_F1_12);
      access("R7", 32'h200, 12'(o), 3'b100, 32'h0000_00C3, 32'h80_7F_F1_12);
      access("R3", 32'h300 + o, 12'h0, 3'b000, 32'h1234_5678, 32'h0);
      cmp("R3", "byte strobe", {28'h0, byteEn}, 32'(1 << o));
    end
    cmp("R5", "byte lanes", storeLanes, 32'h7878_7878);
  endtask

  task automatic testHalves;
    access("R6", 32'h400, 12'h0, 3'b001, 32'hDEAD_BEEF, 32'h1234_8001);
    cmp("R6", "signed low half", loadResult, 32'hFFFF_8001);
    access("R6", 32'h402, 12'h0, 3'b001, 32'hDEAD_BEEF, 32'h9ABC_0001);
    cmp("R6", "signed high half", loadResult, 32'hFFFF_9ABC);
    access("R7", 32'h402, 12'h0, 3'b101, 32'hDEAD_BEEF, 32'h9ABC_0001);
    cmp("R7", "unsigned high half", loadResult, 32'h0000_9ABC);
    cmp("R5", "half lanes", storeLanes, 32'hBEEF_BEEF);
    cmp("R3", "upper half strobes", {28'h0, byteEn}, 32'hC);
  endtask

  task automatic testWord;
    access("R8", 32'h500, 12'h10, 3'b010, 32'hCAFE_F00D, 32'h8765_4321);
    cmp("R8", "word load", loadResult, 32'h8765_4321);
    cmp("R5", "word store", storeLanes, 32'hCAFE_F00D);
  endtask

  task automatic testMisaligned;
    access("R4", 32'h601, 12'h0, 3'b001, 32'h1, 32'hFFFF_FFFF);
    access("R4", 32'h603, 12'h0, 3'b101, 32'h1, 32'hFFFF_FFFF);
    for (int o = 1; o < 4; o++) begin
      access("R9", 32'h700, 12'(o), 3'b010, 32'h1, 32'hFFFF_FFFF);
      cmp("R4", "word misaligned flag", {31'h0, misaligned}, 32'h1);
    end
  endtask

  task automatic testIllegal;
    logic [2:0] bad [3] = '{3'b011, 3'b110, 3'b111};
    for (int k = 0; k < 3; k++) begin
      access("R2", 32'h801, 12'h0, bad[k], 32'h5566_7788, 32'hFFFF_FFFF);
      cmp("R2", "illegal strobes", {28'h0, byteEn}, 32'h0);
    end
  endtask

  initial begin
    testIdle();
    testAddress();
    testBytes();
    testHalves();
    testWord();
    testMisaligned();
    testIllegal();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule